// File: doc/BRIEF.md
# Strobe-on-Data Serial-to-Parallel Sink Driver

This block receives a slow two-wire serial stream and drives twelve open-drain style sink outputs, such as LED cathodes returned through external pull-ups. It has no separate load pin. The data wire carries the shift bits, and its level at each falling serial-clock edge decides whether the shifted word is made visible on the outputs.

A rising serial-clock edge pushes the data level into stage 0 of a 12-bit shift chain. Every older bit moves one stage toward stage 11. On a falling edge, a high data level copies the whole chain at once into the output latch. A low data level leaves the latch alone. Both serial wires are brought into a fast system clock domain through multi-flop synchronizers, and edges are found by comparing successive synchronized clock samples. The serial pins are plain level inputs, so there is no stream handshake and no back-pressure. The sender paces itself by holding each serial level long enough.

Each output bit asks for its pin to be pulled low when the latched bit is 0, and releases the pin when the latched bit is 1. A read-only copy of the latch is also brought out.

Top module: `sipo_strobe_driver`

## Requirements
- R1: Synchronous reset (rst high at a clk edge) clears the shift chain to 0 and sets every latch bit to 1, so latch_view_o = 12'hFFF and pull_low_o = 12'h000 after reset.
- R2: On each detected rising serial-clock edge, the synchronized data level enters chain bit 0, and chain bit i moves to bit i+1. With no rising edge, the chain holds.
- R3: After twelve rising edges, the first bit sent is at bit 11 (Q11) and the last bit sent is at bit 0 (Q0). A word sent most-significant bit first therefore appears unchanged.
- R4: On a detected falling edge with the data line high, all twelve chain bits are copied at once into the latch, including a chain that holds fewer than twelve fresh bits.
- R5: On a detected falling edge with the data line low, the latch keeps its value.
- R6: pull_low_o[i] is 1 exactly when latch_view_o[i] is 0. A 1 means pin i is driven low; a 0 means the pin is released.
- R7: The latch decision uses the data sample synchronized in the same system cycle in which the falling edge is seen. A data rise that arrives one system cycle after the clock fall does not load the latch.
- R8: With no serial-clock edge, data-line activity changes neither the latch nor the outputs. A rising and a falling edge are never detected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times faster than the shortest serial level |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial shift clock |
| ser_dat_i | input | 1 | Asynchronous serial data and latch strobe |
| pull_low_o | output | 12 | Per-pin sink enable, 1 = pin pulled low |
| latch_view_o | output | 12 | Read-only copy of the output latch |

## Verification
The assertions assume that ser_clk_i and ser_dat_i each hold a level for several system cycles. This keeps the synchronized clock free of glitches and ensures that each serial edge appears as one clean rise or fall, with data settled around it. The stimulus changes a serial wire only at a falling system-clock edge and keeps every serial phase eight system cycles long. The one exception is the R7 case, where data rises a single cycle after a clock fall. Even then, the clock wire itself never toggles faster than the bound.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int SIPO_WIDTH  = 12;
  localparam int SIPO_STAGES = 2;
endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sipo_edge.sv
module sipo_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~prev_q;
  assign fall_o = ~sclk_i & prev_q;

  assert_one_edge_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/sipo_shift.sv
module sipo_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise_i,
  input  logic         dat_i,
  output logic [W-1:0] chain_o
);
  logic [W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst)         chain_q <= '0;
    else if (rise_i) chain_q <= {chain_q[W-2:0], dat_i};
  end

  assign chain_o = chain_q;

  assert_shift_move_R2: assert property (@(posedge clk) disable iff (rst)
    rise_i |=> (chain_q[W-1:1] == $past(chain_q[W-2:0])) && (chain_q[0] == $past(dat_i)));

  assert_shift_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rise_i |=> $stable(chain_q));
endmodule

// File: rtl/sipo_latch.sv
module sipo_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fall_i,
  input  logic         dat_i,
  input  logic [W-1:0] chain_i,
  output logic [W-1:0] latch_o
);
  logic [W-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst)                  latch_q <= '1;
    else if (fall_i && dat_i) latch_q <= chain_i;
  end

  assign latch_o = latch_q;

  assert_reset_ones_R1: assert property (@(posedge clk)
    rst |=> (latch_q == {W{1'b1}}));

  assert_strobe_load_R4: assert property (@(posedge clk) disable iff (rst)
    (fall_i && dat_i) |=> (latch_q == $past(chain_i)));

  assert_low_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(fall_i && dat_i) |=> $stable(latch_q));
endmodule

// File: rtl/sipo_strobe_driver.sv
module sipo_strobe_driver
  import sipo_pkg::*;
#(
  parameter int WIDTH  = SIPO_WIDTH,
  parameter int STAGES = SIPO_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  output logic [WIDTH-1:0] pull_low_o,
  output logic [WIDTH-1:0] latch_view_o
);
  logic [1:0]       sync_w;
  logic             s_clk, s_dat, rise, fall;
  logic [WIDTH-1:0] chain, latch_w;

  sipo_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i({ser_clk_i, ser_dat_i}), .sync_o(sync_w)
  );
  assign s_clk = sync_w[1];
  assign s_dat = sync_w[0];

  sipo_edge u_edge (
    .clk(clk), .rst(rst), .sclk_i(s_clk), .rise_o(rise), .fall_o(fall)
  );

  sipo_shift #(.W(WIDTH)) u_shift (
    .clk(clk), .rst(rst), .rise_i(rise), .dat_i(s_dat), .chain_o(chain)
  );

  sipo_latch #(.W(WIDTH)) u_latch (
    .clk(clk), .rst(rst), .fall_i(fall), .dat_i(s_dat), .chain_i(chain), .latch_o(latch_w)
  );

  assign latch_view_o = latch_w;
  assign pull_low_o   = ~latch_w;

  assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(latch_view_o));
endmodule

// File: tb/sipo_strobe_driver_bench.sv
module sipo_strobe_driver_bench;
  localparam int W     = 12;
  localparam int PHASE = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic sdt = 1'b0;
  logic [W-1:0] pull_low, latch_view;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [W-1:0] exp_latch;

  // table entry: bit 12 = raise data before the last falling edge, bits 11:0 = word
  localparam logic [12:0] VEC [6] = '{
    {1'b1, 12'hA5C}, {1'b0, 12'h3F0}, {1'b1, 12'h0F1},
    {1'b1, 12'hFFF}, {1'b0, 12'h000}, {1'b1, 12'h000}
  };

  always #2 clk = ~clk;

  sipo_strobe_driver u_sipo_strobe_driver (
    .clk(clk), .rst(rst), .ser_clk_i(sck), .ser_dat_i(sdt),
    .pull_low_o(pull_low), .latch_view_o(latch_view)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic strobe);
    sdt = b;      wait_cyc(PHASE);
    sck = 1'b1;   wait_cyc(PHASE);
    sdt = strobe; wait_cyc(PHASE);
    sck = 1'b0;   wait_cyc(PHASE);
    sdt = 1'b0;   wait_cyc(PHASE);
  endtask

  initial begin
    wait_cyc(6);
    check("R1 latch", latch_view, 12'hFFF);
    check("R1 pull_low", pull_low, 12'h000);
    rst = 1'b0;
    wait_cyc(4);
    exp_latch = 12'hFFF;

    // table walk: each word sent MSB first (R3), latch untouched mid-word (R5)
    for (int v = 0; v < 6; v++) begin
      for (int i = W-1; i >= 0; i--) begin
        send_bit(VEC[v][i], (i == 0) ? VEC[v][12] : 1'b0);
        if (i != 0) check("R5 no load mid-word", latch_view, exp_latch);
      end
      if (VEC[v][12]) exp_latch = VEC[v][W-1:0];
      check("R3/R4 latch after word", latch_view, exp_latch);
      check("R6 pull_low inverse", pull_low, ~exp_latch);
    end

    // R2 partial word: reset, send 1,0,1 with strobe on third
    rst = 1'b1; wait_cyc(4); rst = 1'b0; wait_cyc(4);
    check("R1 reset again", latch_view, 12'hFFF);
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b1);
    check("R2 shift direction / R4 partial load", latch_view, 12'h005);
    check("R6 pull_low partial", pull_low, 12'hFFA);

    // R7: data rises one system cycle after the clock fall -> no load
    sdt = 1'b0; wait_cyc(PHASE);
    sck = 1'b1; wait_cyc(PHASE);
    sck = 1'b0; wait_cyc(1);
    sdt = 1'b1; wait_cyc(2 * PHASE);
    check("R7 late data rise ignored", latch_view, 12'h005);
    // R8: data toggles with no clock edge
    sdt = 1'b0; wait_cyc(PHASE);
    sdt = 1'b1; wait_cyc(PHASE);
    check("R8 data toggle without edge", latch_view, 12'h005);
    sdt = 1'b0; wait_cyc(PHASE);
    // the chain now holds 12'b1010 (extra 0 shifted in): a strobed bit 1 gives 12'h015
    send_bit(1'b1, 1'b1);
    check("R4 strobe after R7 case", latch_view, 12'h015);
    check("R6 pull_low after strobe", pull_low, 12'hFEA);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule